// File: doc/BRIEF.md
# Interrupt-Capable Parallel Pin Controller

This block drives and samples a bank of general-purpose pins from a small word-addressed register bus. Software chooses a direction and an open-drain flag for each pin and sets the output levels through a data register. Reading that same data register returns a merged view: the driven value for output pins and the synchronised pad level for input pins.

Every pin is watched for transitions at all times. A detected transition latches a sticky event bit that stays set until software writes a one to it. A per-pin control bit picks whether only falling edges count or whether both edges count. A mask register gates the sticky events onto one level-sensitive interrupt line.

Register bits use most-significant-first pin numbering. The pad vectors are indexed by pin number, so the block reverses bit order between the pads and the registers. The block has no state machine. It is a fixed pipeline: the pad passes two synchroniser flops and a history flop, then the sticky event register, then the mask gate. Outside reset it has one steady operating condition and no transitions between modes.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: Pin n (0..31) corresponds to register bit 31-n in every register. The pad vectors `pad_in`, `pad_out` and `pad_oe` are indexed directly by pin number.
- R2: `bus_addr` is a word index: 0 direction, 1 open-drain, 2 data, 3 event, 4 mask, 5 edge control. Registers 0, 1, 4 and 5 read back the last value written. Reads are combinational while `bus_rd` is high and return zero while `bus_rd` is low.
- R3: A direction bit of 1 makes its pin an output: `pad_oe` for that pin is 1 unless R8 applies, and `pad_out` carries the data bit. A direction bit of 0 makes `pad_oe` 0.
- R4: Writing the event register clears each bit written as 1 and leaves each bit written as 0 unchanged. Without a write, event bits never fall.
- R5: Edge-control bit 1 means only a falling pin level sets the event bit; 0 means rising and falling both set it. A pad change driven before a clock edge shows in the event register after the third rising clock edge.
- R6: `irq` is high exactly while some bit of (event AND mask) is 1. A mask bit of 1 enables its pin.
- R7: A data-register read returns, per bit, the synchronised pad level where the direction bit is 0 and the last written data bit where the direction bit is 1.
- R8: When a pin's direction and open-drain bits are both 1, `pad_oe` is 1 only while its data bit is 0.
- R9: If a new edge and a write-one-to-clear hit the same event bit in the same cycle, the bit stays set. Other bits written as 1 are cleared.
- R10: Reset sets every register, `irq` and `pad_oe` to zero. Reads of word indices 6 and 7 return zero, and writes to them change no register.
- R11: A pad level is seen by data-register reads only after two rising clock edges (two-flop synchroniser).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 3 | Register word index |
| bus_wr | input | 1 | Single-cycle write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational |
| pad_in | input | 32 | Pad levels, index = pin number |
| pad_out | output | 32 | Output values, index = pin number |
| pad_oe | output | 32 | Output enables, index = pin number |
| irq | output | 1 | Level interrupt |

## Verification
The bench sweeps every pin through rising and falling transitions in both edge-control settings. A design that skipped the bit reversal, or swapped the meaning of the control bit, would show the event on the wrong bit or for the wrong edge. It also lines up a new edge exactly with a clear-all write, so a design where the clear wins loses a real event. Separate checks cover unmapped-index writes, which would corrupt a real register if decoded loosely, and synchroniser latency, where a missing flop shows the pad level one cycle early. The merged data readback is checked against an arithmetic mix of the pad pattern and the written outputs, which catches a design that returns only one of the two.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
    localparam int unsigned GP_PINS = 32;
    localparam int unsigned GP_AW   = 3;

    typedef enum logic [GP_AW-1:0] {
        RG_DIR = 3'd0,
        RG_ODE = 3'd1,
        RG_DAT = 3'd2,
        RG_EVT = 3'd3,
        RG_MSK = 3'd4,
        RG_ICT = 3'd5
    } reg_sel_e;
endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
    parameter int unsigned W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pin_i,
    output logic [W-1:0] lvl_o,
    output logic [W-1:0] rise_o,
    output logic [W-1:0] fall_o
);
    logic [W-1:0] meta_q;
    logic [W-1:0] sync_q;
    logic [W-1:0] hist_q;

    for (genvar i = 0; i < W; i++) begin : g_bit
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                meta_q[i] <= 1'b0;
                sync_q[i] <= 1'b0;
                hist_q[i] <= 1'b0;
            end else begin
                meta_q[i] <= pin_i[i];
                sync_q[i] <= meta_q[i];
                hist_q[i] <= sync_q[i];
            end
        end

        always_comb begin
            rise_o[i] = sync_q[i] & ~hist_q[i];
            fall_o[i] = ~sync_q[i] & hist_q[i];
        end
    end

    assign lvl_o = sync_q;
endmodule

// File: rtl/gpio_evt.sv
module gpio_evt #(
    parameter int unsigned W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr_en,
    input  logic [W-1:0] clr_mask,
    input  logic [W-1:0] rise,
    input  logic [W-1:0] fall,
    input  logic [W-1:0] fall_only,
    output logic [W-1:0] evt_o
);
    logic [W-1:0] set_v;
    logic [W-1:0] clr_v;
    logic [W-1:0] evt_q;

    always_comb begin
        set_v = fall | (rise & ~fall_only);
        clr_v = clr_en ? clr_mask : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) evt_q <= '0;
        else        evt_q <= (evt_q & ~clr_v) | set_v;
    end

    assign evt_o = evt_q;

    AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        clr_en |=> ((evt_q & $past(clr_mask & ~set_v)) == '0)); // R4
    AST_EVT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_en |=> (($past(evt_q) & ~evt_q) == '0)); // R4
    AST_EDGE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (set_v != '0) |=> ((evt_q & $past(set_v)) == $past(set_v))); // R9
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
    import gpio_pkg::*;
#(
    parameter int unsigned W  = 32,
    parameter int unsigned AW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] addr,
    input  logic          wr,
    input  logic          rd,
    input  logic [W-1:0]  wdata,
    input  logic [W-1:0]  lvl,
    input  logic [W-1:0]  evt,
    output logic [W-1:0]  dir_o,
    output logic [W-1:0]  ode_o,
    output logic [W-1:0]  dat_o,
    output logic [W-1:0]  msk_o,
    output logic [W-1:0]  ict_o,
    output logic          evt_wr_o,
    output logic [W-1:0]  rdata
);
    logic [W-1:0] dir_q, ode_q, dat_q, msk_q, ict_q;
    logic [W-1:0] rd_mux;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dir_q <= '0;
            ode_q <= '0;
            dat_q <= '0;
            msk_q <= '0;
            ict_q <= '0;
        end else if (wr) begin
            case (addr)
                RG_DIR:  dir_q <= wdata;
                RG_ODE:  ode_q <= wdata;
                RG_DAT:  dat_q <= wdata;
                RG_MSK:  msk_q <= wdata;
                RG_ICT:  ict_q <= wdata;
                default: ;
            endcase
        end
    end

    always_comb begin
        case (addr)
            RG_DIR:  rd_mux = dir_q;
            RG_ODE:  rd_mux = ode_q;
            RG_DAT:  rd_mux = (lvl & ~dir_q) | (dat_q & dir_q);
            RG_EVT:  rd_mux = evt;
            RG_MSK:  rd_mux = msk_q;
            RG_ICT:  rd_mux = ict_q;
            default: rd_mux = '0;
        endcase
        rdata = rd ? rd_mux : '0;
    end

    assign evt_wr_o = wr && (addr == RG_EVT);
    assign dir_o = dir_q;
    assign ode_o = ode_q;
    assign dat_o = dat_q;
    assign msk_o = msk_q;
    assign ict_o = ict_q;

    AST_UNMAPPED_RD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && (addr > RG_ICT)) |-> (rdata == '0)); // R10
endmodule

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl
    import gpio_pkg::*;
#(
    parameter int unsigned PINS = GP_PINS,
    parameter int unsigned AW   = GP_AW
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [AW-1:0]   bus_addr,
    input  logic            bus_wr,
    input  logic            bus_rd,
    input  logic [PINS-1:0] bus_wdata,
    output logic [PINS-1:0] bus_rdata,
    input  logic [PINS-1:0] pad_in,
    output logic [PINS-1:0] pad_out,
    output logic [PINS-1:0] pad_oe,
    output logic            irq
);
    localparam int unsigned TOP = PINS - 1;

    logic [PINS-1:0] pin_r;
    logic [PINS-1:0] lvl_r, rise_r, fall_r;
    logic [PINS-1:0] dir_r, ode_r, dat_r, msk_r, ict_r, evt_r;
    logic [PINS-1:0] oe_r;
    logic            evt_wr;

    for (genvar n = 0; n < PINS; n++) begin : g_swap
        assign pin_r[TOP-n] = pad_in[n];
        assign pad_out[n]   = dat_r[TOP-n];
        assign pad_oe[n]    = oe_r[TOP-n];
    end

    gpio_in_sync #(.W(PINS)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .pin_i  (pin_r),
        .lvl_o  (lvl_r),
        .rise_o (rise_r),
        .fall_o (fall_r)
    );

    gpio_regs #(.W(PINS), .AW(AW)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .addr     (bus_addr),
        .wr       (bus_wr),
        .rd       (bus_rd),
        .wdata    (bus_wdata),
        .lvl      (lvl_r),
        .evt      (evt_r),
        .dir_o    (dir_r),
        .ode_o    (ode_r),
        .dat_o    (dat_r),
        .msk_o    (msk_r),
        .ict_o    (ict_r),
        .evt_wr_o (evt_wr),
        .rdata    (bus_rdata)
    );

    gpio_evt #(.W(PINS)) u_evt (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr_en    (evt_wr),
        .clr_mask  (bus_wdata),
        .rise      (rise_r),
        .fall      (fall_r),
        .fall_only (ict_r),
        .evt_o     (evt_r)
    );

    always_comb begin
        oe_r = dir_r & ~(ode_r & dat_r);
        irq  = |(evt_r & msk_r);
    end

    AST_IRQ_NEEDS_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (msk_r != '0)); // R6
    AST_OD_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        ((pad_oe & pad_out & {<<{ode_r}}) == '0)); // R8
endmodule

// File: tb/gpio_irq_ctrl_tb_top.sv
`timescale 1ns/1ps
module gpio_irq_ctrl_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [31:0] pad_in = '0;
    logic [31:0] pad_out;
    logic [31:0] pad_oe;
    logic        irq;

    int total = 0;
    int bad = 0;

    always #2.5 clk = ~clk;

    gpio_irq_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe), .irq(irq)
    );

    function automatic logic [31:0] bitof(int n);
        return 32'h1 << (31 - n);
    endfunction

    function automatic logic [31:0] rev(logic [31:0] v);
        logic [31:0] r;
        for (int i = 0; i < 32; i++) r[31-i] = v[i];
        return r;
    endfunction

    task automatic chk(input logic [31:0] got, input logic [31:0] exp, input string tag);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    task automatic bwrite(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bread(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1;
        d = bus_rdata;
        bus_rd = 1'b0;
    endtask

    task automatic set_pad(input logic [31:0] v);
        @(negedge clk);
        pad_in = v;
        repeat (3) @(posedge clk);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [31:0] rv;
        logic [31:0] dirv;
        logic [31:0] datv;
        logic [31:0] padv;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R10 reset state
        for (int a = 0; a < 8; a++) begin
            bread(a[2:0], rv);
            chk(rv, 32'h0, "R10 reset read");
        end
        chk(pad_oe, 32'h0, "R10 reset pad_oe");
        chk({31'h0, irq}, 32'h0, "R10 reset irq");

        // R2 readback of plain registers
        bwrite(3'd0, 32'hFFFF_FFFF);
        bwrite(3'd1, 32'h0F0F_0F0F);
        bwrite(3'd2, 32'h1357_9BDF);
        bwrite(3'd4, 32'hA5A5_0001);
        bwrite(3'd5, 32'h8000_7FFE);
        // R10 unmapped writes ignored
        bwrite(3'd6, 32'h5555_AAAA);
        bwrite(3'd7, 32'hDEAD_BEEF);
        bread(3'd0, rv); chk(rv, 32'hFFFF_FFFF, "R2 dir");
        bread(3'd1, rv); chk(rv, 32'h0F0F_0F0F, "R2 od");
        bread(3'd2, rv); chk(rv, 32'h1357_9BDF, "R2 data");
        bread(3'd4, rv); chk(rv, 32'hA5A5_0001, "R2 mask");
        bread(3'd5, rv); chk(rv, 32'h8000_7FFE, "R2 ictl");
        bread(3'd3, rv); chk(rv, 32'h0, "R10 event untouched");
        bread(3'd6, rv); chk(rv, 32'h0, "R10 unmapped 6");
        bread(3'd7, rv); chk(rv, 32'h0, "R10 unmapped 7");
        bwrite(3'd1, 32'h0);
        bwrite(3'd4, 32'h0);

        // R1 R3 output mapping sweep
        for (int p = 0; p < 4; p++) begin
            dirv = (p == 0) ? 32'hFFFF_0000 : (p == 1) ? 32'h00FF_FF00 :
                   (p == 2) ? 32'hF0F0_F0F0 : 32'h8000_0001;
            datv = 32'h6A3C_95E1 ^ (32'h1111_1111 * p);
            bwrite(3'd0, dirv);
            bwrite(3'd2, datv);
            chk(pad_oe, rev(dirv), "R3 pad_oe per direction");
            chk(pad_out, rev(datv), "R1 pad_out reversed");
        end

        // R8 open drain
        bwrite(3'd0, bitof(2) | bitof(4));
        bwrite(3'd1, bitof(4));
        bwrite(3'd2, bitof(2) | bitof(4));
        chk({30'h0, pad_oe[4], pad_oe[2]}, 32'h1, "R8 od high released");
        chk({31'h0, pad_out[4]}, 32'h1, "R8 od pad_out");
        bwrite(3'd2, bitof(2));
        chk({30'h0, pad_oe[4], pad_oe[2]}, 32'h3, "R8 od low driven");
        bwrite(3'd1, 32'h0);
        bwrite(3'd0, 32'h0);

        // R11 synchroniser latency (all inputs)
        @(negedge clk) pad_in = 32'h0000_0001;
        bread(3'd2, rv); chk(rv, 32'h0, "R11 one edge");
        bread(3'd2, rv); chk(rv, bitof(0), "R11 two edges");
        set_pad(32'h0);
        bwrite(3'd3, 32'hFFFF_FFFF);

        // R5 R1 R4 falling-only sweep
        bwrite(3'd5, 32'hFFFF_FFFF);
        for (int n = 0; n < 32; n++) begin
            set_pad(32'h1 << n);
            bread(3'd3, rv); chk(rv, 32'h0, "R5 rise ignored in falling mode");
            set_pad(32'h0);
            bread(3'd3, rv); chk(rv, bitof(n), "R5 falling sets bit 31-n");
            bwrite(3'd3, 32'hFFFF_FFFF);
            bread(3'd3, rv); chk(rv, 32'h0, "R4 clear all");
        end

        // R5 both-edge sweep
        bwrite(3'd5, 32'h0);
        for (int n = 0; n < 32; n++) begin
            set_pad(32'h1 << n);
            bread(3'd3, rv); chk(rv, bitof(n), "R5 rise in both mode");
            bwrite(3'd3, bitof(n));
            set_pad(32'h0);
            bread(3'd3, rv); chk(rv, bitof(n), "R5 fall in both mode");
            bwrite(3'd3, bitof(n));
        end

        // R4 write zero leaves others
        set_pad(32'h0000_0013);
        bwrite(3'd3, bitof(1));
        bread(3'd3, rv); chk(rv, bitof(0) | bitof(4), "R4 partial clear");

        // R6 irq gating
        chk({31'h0, irq}, 32'h0, "R6 masked no irq");
        bwrite(3'd4, bitof(1));
        chk({31'h0, irq}, 32'h0, "R6 mask on cleared bit");
        bwrite(3'd4, bitof(4));
        chk({31'h0, irq}, 32'h1, "R6 mask enables irq");
        bwrite(3'd3, bitof(4));
        chk({31'h0, irq}, 32'h0, "R6 irq drops on clear");
        bwrite(3'd4, 32'h0);
        set_pad(32'h0);
        bwrite(3'd3, 32'hFFFF_FFFF);

        // R9 edge and clear collide
        set_pad(32'h0000_0088);          // pins 3 and 7 rise
        bread(3'd3, rv); chk(rv, bitof(3) | bitof(7), "R9 preset");
        @(negedge clk) pad_in = 32'h0000_0080; // pin 3 falls
        @(posedge clk);
        @(posedge clk);
        @(negedge clk);
        bus_addr = 3'd3; bus_wdata = 32'hFFFF_FFFF; bus_wr = 1'b1;
        @(negedge clk) bus_wr = 1'b0;
        bread(3'd3, rv); chk(rv, bitof(3), "R9 edge wins over clear");
        set_pad(32'h0);
        bwrite(3'd3, 32'hFFFF_FFFF);

        // R7 merged data readback
        for (int p = 0; p < 3; p++) begin
            dirv = (p == 0) ? 32'h0000_FFFF : (p == 1) ? 32'hFF00_00FF : 32'h5555_5555;
            datv = 32'h1234_5678 + 32'h0101_0101 * p;
            padv = 32'hC3A5_0F96 ^ (32'h0F0F_0F0F * p);
            bwrite(3'd0, dirv);
            bwrite(3'd2, datv);
            set_pad(padv);
            bread(3'd2, rv);
            chk(rv, (rev(padv) & ~dirv) | (datv & dirv), "R7 merged read");
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule